// File: doc/BRIEF.md
# Pixel Array Readout Timing Generator

This block sequences the readout of a progressive-scan pixel array from one master clock. It walks a rectangular window of interest in row-major order, one pixel per clock. For each pixel it gives the row and column address, a pixel-valid level, a one-cycle line strobe on the first pixel of each line, and a one-cycle frame strobe on the first pixel of each frame. Pixels that fall in the dark or isolation borders of the physical array are still read, but a border flag marks them.

The window position, the window size and the horizontal and vertical blanking counts are plain parallel inputs. They are copied into shadow registers only at a frame boundary, so a frame in flight never changes shape. In continuous mode frames follow each other without pause. In the two single-frame modes, each rising edge on the trigger input starts one frame. The init input is a synchronous soft reset, and it acts only after it has been held for a minimum number of clocks.

Top module: `sensor_readout_tg`

## Requirements
- R1: When `init_i` is high on 4 consecutive rising clock edges, the block returns to idle on the 4th edge and stays idle while `init_i` stays high. A high pulse of 3 clocks or fewer has no effect on the outputs.
- R2: In continuous mode (`mode_i` = 00 or 11), a frame starts on the first clock edge after the block is idle. After the last pixel and the vertical blanking of a frame, the next frame starts at once.
- R3: In single-frame modes (`mode_i` = 01 or 10), a 0-to-1 change on `sync_i` seen while idle starts exactly one frame, and the block returns to idle after it. A rising edge that comes while a frame is in progress is dropped and is not queued.
- R4: Within a frame, each line presents columns from the window start up to the window end, one per clock, with `pix_o` active. Lines advance from the start row to the end row. `row_o` and `col_o` carry the address during pixel cycles and read zero otherwise.
- R5: `sof_o` is active for exactly the first pixel cycle of a frame (start row, start column). `line_o` is active on the first pixel cycle of every line.
- R6: Between two lines there are exactly `cfg_hblank_i` idle cycles. After the last line there are exactly `cfg_vblank_i` idle cycles. A count of zero inserts none.
- R7: Window and blanking inputs are sampled only when a frame starts. A change during a frame affects only the following frame.
- R8: A start row above 501 is clamped to 501, and a start column above 655 is clamped to 655. A size of zero is taken as one. A window end past the array is clamped to the last row (501) or the last column (655).
- R9: `border_o` is high during a pixel cycle whose column is below 12 or at least 644, or whose row is below 4 or at least 498. It is low at all other times.
- R10: `cfg_pol_i` bit 0 inverts `sof_o`, bit 1 inverts `line_o` and bit 2 inverts `pix_o`. The inversion takes effect on the same cycle.
- R11: After `rst_ni` is asserted, the block is idle: no pixel, line or frame strobe is active, and the addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous soft reset, must be held 4 clocks |
| sync_i | input | 1 | Single-frame trigger, rising edge |
| mode_i | input | 2 | 00/11 continuous, 01/10 single frame |
| cfg_row_start_i | input | 10 | Window first row |
| cfg_col_start_i | input | 10 | Window first column |
| cfg_width_i | input | 10 | Window width in columns |
| cfg_height_i | input | 10 | Window height in rows |
| cfg_hblank_i | input | 8 | Idle cycles between lines |
| cfg_vblank_i | input | 8 | Idle cycles after the last line |
| cfg_pol_i | input | 3 | Output inversion: bit0 frame, bit1 line, bit2 pixel |
| sof_o | output | 1 | Frame-start strobe |
| line_o | output | 1 | Line-start strobe |
| pix_o | output | 1 | Pixel valid |
| row_o | output | 10 | Current row address |
| col_o | output | 10 | Current column address |
| border_o | output | 1 | Current pixel lies in a dark or isolation border |

## Verification
On every cycle the assertions check the following. The column steps by exactly one inside a line. Addresses never leave the latched window. The shadowed window never leaves the array. Blanking counters stay within their programmed range. An idle single-frame block without a trigger stays idle. The init filter never fires on the first cycle of a pulse. The bench's reference model shows the behaviours that depend on sequences of stimulus: exact blanking lengths between frames, the deferral of window changes to the next frame, a trigger dropped mid-frame, a 3-clock init that is ignored next to a 4-clock one that takes effect, clamping at the array corner, and border flagging at the right edge.

// File: rtl/sro_pkg.sv
package sro_pkg;
  localparam int ARR_COLS = 656;
  localparam int ARR_ROWS = 502;
  localparam int AW       = $clog2(ARR_COLS);
  localparam int BW       = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINE = 2'd1,
    ST_HBL  = 2'd2,
    ST_VBL  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [AW-1:0] rs;
    logic [AW-1:0] cs;
    logic [AW-1:0] re;
    logic [AW-1:0] ce;
    logic [BW-1:0] hb;
    logic [BW-1:0] vb;
  } win_t;
endpackage

// File: rtl/sro_init_filter.sv
module sro_init_filter #(
  parameter int INIT_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  output logic hold_o
);
  localparam int CW = $clog2(INIT_MIN) + 1;
  localparam logic [CW-1:0] CMAX = CW'(INIT_MIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!init_i) cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
  end

  assign hold_o = init_i && (cnt_q == CMAX);

  // short pulses never act on their first cycle
  p_no_early_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> !hold_o);
  p_rise_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_i) |-> !hold_o);
endmodule

// File: rtl/sro_win_clamp.sv
module sro_win_clamp
  import sro_pkg::*;
(
  input  logic [AW-1:0] row_start_i,
  input  logic [AW-1:0] col_start_i,
  input  logic [AW-1:0] width_i,
  input  logic [AW-1:0] height_i,
  input  logic [BW-1:0] hblank_i,
  input  logic [BW-1:0] vblank_i,
  output win_t          win_o
);
  logic [1:0][AW-1:0] st_in, sz_in, st_out, en_out;

  assign st_in[0] = row_start_i;
  assign sz_in[0] = height_i;
  assign st_in[1] = col_start_i;
  assign sz_in[1] = width_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int LIM = (a == 0) ? ARR_ROWS : ARR_COLS;
    localparam logic [AW:0] LAST = (AW+1)'(LIM - 1);
    logic [AW:0] s_ext, z_ext, e_ext;
    always_comb begin
      s_ext = {1'b0, st_in[a]};
      if (s_ext > LAST) s_ext = LAST;
      z_ext = (sz_in[a] == '0) ? (AW+1)'(1) : {1'b0, sz_in[a]};
      e_ext = s_ext + z_ext - (AW+1)'(1);
      if (e_ext > LAST) e_ext = LAST;
    end
    assign st_out[a] = s_ext[AW-1:0];
    assign en_out[a] = e_ext[AW-1:0];
  end

  assign win_o.rs = st_out[0];
  assign win_o.re = en_out[0];
  assign win_o.cs = st_out[1];
  assign win_o.ce = en_out[1];
  assign win_o.hb = hblank_i;
  assign win_o.vb = vblank_i;
endmodule

// File: rtl/sro_sequencer.sv
module sro_sequencer
  import sro_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          cont_i,
  input  logic          trig_i,
  input  win_t          win_i,
  output logic          pix_act_o,
  output logic          sof_act_o,
  output logic          line_act_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o
);
  seq_st_e       st_q, st_d;
  logic [AW-1:0] row_q, row_d, col_q, col_d;
  logic [BW-1:0] cnt_q, cnt_d;
  win_t          win_q, win_d;
  logic          frame_end, load;

  always_comb begin
    st_d = st_q; row_d = row_q; col_d = col_q; cnt_d = cnt_q; win_d = win_q;
    frame_end = 1'b0;
    load      = 1'b0;
    unique case (st_q)
      ST_IDLE: load = cont_i || trig_i;
      ST_LINE: begin
        if (col_q != win_q.ce) begin
          col_d = col_q + AW'(1);
        end else if (row_q != win_q.re) begin
          if (win_q.hb == '0) begin
            row_d = row_q + AW'(1);
            col_d = win_q.cs;
          end else begin
            st_d  = ST_HBL;
            cnt_d = win_q.hb;
          end
        end else if (win_q.vb == '0) begin
          frame_end = 1'b1;
        end else begin
          st_d  = ST_VBL;
          cnt_d = win_q.vb;
        end
      end
      ST_HBL: begin
        if (cnt_q == BW'(1)) begin
          st_d  = ST_LINE;
          row_d = row_q + AW'(1);
          col_d = win_q.cs;
        end else begin
          cnt_d = cnt_q - BW'(1);
        end
      end
      ST_VBL: begin
        if (cnt_q == BW'(1)) frame_end = 1'b1;
        else                 cnt_d = cnt_q - BW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (frame_end) begin
      if (cont_i) load = 1'b1;
      else        st_d = ST_IDLE;
    end
    if (load) begin
      win_d = win_i;
      st_d  = ST_LINE;
      row_d = win_i.rs;
      col_d = win_i.cs;
    end
    if (soft_rst_i) begin
      st_d  = ST_IDLE;
      row_d = '0;
      col_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      cnt_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      col_q <= col_d;
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  assign pix_act_o  = (st_q == ST_LINE);
  assign line_act_o = pix_act_o && (col_q == win_q.cs);
  assign sof_act_o  = line_act_o && (row_q == win_q.rs);
  assign row_o      = pix_act_o ? row_q : '0;
  assign col_o      = pix_act_o ? col_q : '0;

  p_col_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_act_o |-> (col_q >= win_q.cs) && (col_q <= win_q.ce) &&
                  (row_q >= win_q.rs) && (row_q <= win_q.re));
  p_col_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_act_o && $past(pix_act_o) && col_q != win_q.cs) |->
      col_q == $past(col_q) + AW'(1));
  p_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q.re < AW'(ARR_ROWS)) && (win_q.ce < AW'(ARR_COLS)) &&
    (win_q.rs <= win_q.re) && (win_q.cs <= win_q.ce));
  p_blank_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HBL) |-> (cnt_q != '0) && (cnt_q <= win_q.hb));
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !cont_i && !trig_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/sensor_readout_tg.sv
module sensor_readout_tg
  import sro_pkg::*;
#(
  parameter int BORDER_COLS = 12,
  parameter int BORDER_ROWS = 4,
  parameter int INIT_MIN    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          sync_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] cfg_row_start_i,
  input  logic [AW-1:0] cfg_col_start_i,
  input  logic [AW-1:0] cfg_width_i,
  input  logic [AW-1:0] cfg_height_i,
  input  logic [BW-1:0] cfg_hblank_i,
  input  logic [BW-1:0] cfg_vblank_i,
  input  logic [2:0]    cfg_pol_i,
  output logic          sof_o,
  output logic          line_o,
  output logic          pix_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          border_o
);
  localparam logic [AW-1:0] BC_LO = AW'(BORDER_COLS);
  localparam logic [AW-1:0] BC_HI = AW'(ARR_COLS - BORDER_COLS);
  localparam logic [AW-1:0] BR_LO = AW'(BORDER_ROWS);
  localparam logic [AW-1:0] BR_HI = AW'(ARR_ROWS - BORDER_ROWS);

  logic hold, sync_q, cont, trig;
  logic pix_act, sof_act, line_act;
  win_t win_live;

  sro_init_filter #(.INIT_MIN(INIT_MIN)) u_init (
    .clk_i (clk_i), .rst_ni (rst_ni), .init_i (init_i), .hold_o (hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign cont = (mode_i == 2'b00) || (mode_i == 2'b11);
  assign trig = !cont && sync_i && !sync_q;

  sro_win_clamp u_clamp (
    .row_start_i (cfg_row_start_i),
    .col_start_i (cfg_col_start_i),
    .width_i     (cfg_width_i),
    .height_i    (cfg_height_i),
    .hblank_i    (cfg_hblank_i),
    .vblank_i    (cfg_vblank_i),
    .win_o       (win_live)
  );

  sro_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (hold),
    .cont_i     (cont),
    .trig_i     (trig),
    .win_i      (win_live),
    .pix_act_o  (pix_act),
    .sof_act_o  (sof_act),
    .line_act_o (line_act),
    .row_o      (row_o),
    .col_o      (col_o)
  );

  assign sof_o    = sof_act  ^ cfg_pol_i[0];
  assign line_o   = line_act ^ cfg_pol_i[1];
  assign pix_o    = pix_act  ^ cfg_pol_i[2];
  assign border_o = pix_act && ((col_o < BC_LO) || (col_o >= BC_HI) ||
                                (row_o < BR_LO) || (row_o >= BR_HI));

  p_sof_in_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_act |-> line_act && pix_act);
  p_init_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> !pix_act);
endmodule

// File: tb/sensor_readout_tg_bench.sv
module sensor_readout_tg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, sync = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [9:0] c_rs = '0, c_cs = '0, c_w = 10'd1, c_h = 10'd1;
  logic [7:0] c_hb = '0, c_vb = '0;
  logic [2:0] pol = '0;
  logic sof, line, pix, border;
  logic [9:0] row, col;

  int checks = 0, fails = 0, sof_seen = 0;
  string tag = "R11";
  bit done = 0;

  always #10 clk = ~clk;

  sensor_readout_tg u_sensor_readout_tg (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .sync_i(sync), .mode_i(mode),
    .cfg_row_start_i(c_rs), .cfg_col_start_i(c_cs), .cfg_width_i(c_w),
    .cfg_height_i(c_h), .cfg_hblank_i(c_hb), .cfg_vblank_i(c_vb),
    .cfg_pol_i(pol), .sof_o(sof), .line_o(line), .pix_o(pix),
    .row_o(row), .col_o(col), .border_o(border)
  );

  // behavioural reference: 0 idle, 1 pixel, 2 line gap, 3 frame gap
  int m_st, m_row, m_col, m_left, m_ih;
  int w_rs, w_cs, w_re, w_ce, w_hb, w_vb;
  bit m_sq;

  function automatic int lim(int v, int top);
    return (v > top) ? top : v;
  endfunction

  task automatic begin_frame();
    w_rs = lim(int'(c_rs), 501);
    w_cs = lim(int'(c_cs), 655);
    w_re = lim(w_rs + ((c_h == 0) ? 1 : int'(c_h)) - 1, 501);
    w_ce = lim(w_cs + ((c_w == 0) ? 1 : int'(c_w)) - 1, 655);
    w_hb = int'(c_hb);
    w_vb = int'(c_vb);
    m_st = 1; m_row = w_rs; m_col = w_cs;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_row = 0; m_col = 0; m_left = 0; m_ih = 0; m_sq = 0;
      w_rs = 0; w_cs = 0; w_re = 0; w_ce = 0; w_hb = 0; w_vb = 0;
    end else begin
      bit go_on, fire, edge_up, finished;
      go_on   = (mode == 2'b00) || (mode == 2'b11);
      edge_up = !go_on && sync && !m_sq;
      fire    = init && (m_ih == 3);
      m_ih    = init ? ((m_ih < 3) ? m_ih + 1 : 3) : 0;
      m_sq    = sync;
      finished = 0;
      if (m_st == 0) begin
        if (go_on || edge_up) begin_frame();
      end else if (m_st == 1) begin
        if (m_col < w_ce) m_col++;
        else if (m_row < w_re) begin
          if (w_hb == 0) begin m_row++; m_col = w_cs; end
          else begin m_st = 2; m_left = w_hb; end
        end else if (w_vb == 0) finished = 1;
        else begin m_st = 3; m_left = w_vb; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_st == 2) begin m_st = 1; m_row++; m_col = w_cs; end
          else finished = 1;
        end
      end
      if (finished) begin
        if (go_on) begin_frame();
        else m_st = 0;
      end
      if (fire) begin m_st = 0; m_row = 0; m_col = 0; end
    end
  end

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 40)
        $display("FAIL %s [%s] t=%0t act=%0d exp=%0d", req, tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!done) begin
      bit e_pix, e_line, e_sof, e_bd;
      e_pix  = (m_st == 1);
      e_line = e_pix && (m_col == w_cs);
      e_sof  = e_line && (m_row == w_rs);
      e_bd   = e_pix && (m_col < 12 || m_col >= 644 || m_row < 4 || m_row >= 498);
      cmp("R5 sof",  int'(sof),  int'(e_sof ^ pol[0]));
      cmp("R5 line", int'(line), int'(e_line ^ pol[1]));
      cmp("R4 pix",  int'(pix),  int'(e_pix ^ pol[2]));
      cmp("R4 row",  int'(row),  e_pix ? m_row : 0);
      cmp("R4 col",  int'(col),  e_pix ? m_col : 0);
      cmp("R9 border", int'(border), int'(e_bd));
      if (sof ^ pol[0]) sof_seen++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_win(int rs, int cs, int w, int h, int hb, int vb);
    c_rs = 10'(rs); c_cs = 10'(cs); c_w = 10'(w); c_h = 10'(h);
    c_hb = 8'(hb); c_vb = 8'(vb);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset state, single mode without trigger stays idle
    set_win(2, 10, 5, 3, 2, 3);
    step(3);
    rst_n = 1'b1;
    step(6);
    cmp("R11 idle pix", int'(pix), 0);
    // R2, R4, R5, R6: continuous readout with blanking
    tag = "R2"; mode = 2'b00;
    step(120);
    // R7: window change mid-frame, right border columns (R9)
    tag = "R7"; set_win(5, 640, 20, 4, 1, 2);
    step(200);
    // R6: zero blanking, back to back lines and frames
    tag = "R6"; set_win(0, 0, 3, 2, 0, 0);
    step(40);
    // R10: output inversion
    tag = "R10"; pol = 3'b101; step(30);
    pol = 3'b010; step(30);
    pol = 3'b000;
    // R1: 3-clock init ignored, 4-clock init returns to idle
    tag = "R1"; set_win(10, 20, 8, 3, 3, 3);
    step(30);
    init = 1'b1; step(3); init = 1'b0;
    step(10);
    cmp("R1 short init", int'(pix === 1'b1 || m_st != 0), 1);
    init = 1'b1; step(6);
    cmp("R1 held init idle", int'(pix), 0);
    mode = 2'b01; init = 1'b0;
    step(10);
    cmp("R1 idle after init", int'(pix), 0);
    // R3: one frame per rising edge, edge during frame dropped
    tag = "R3"; sof_seen = 0;
    sync = 1'b1; step(1); sync = 1'b0;
    step(5);
    sync = 1'b1; step(2); sync = 1'b0;
    step(120);
    cmp("R3 one frame", sof_seen, 1);
    sync = 1'b1; step(60);
    cmp("R3 level no restart", sof_seen, 2);
    sync = 1'b0; mode = 2'b10; step(2);
    sync = 1'b1; step(1); sync = 1'b0; step(100);
    cmp("R3 rolling single", sof_seen, 3);
    // R8: clamping at the array corner, zero sizes
    tag = "R8"; mode = 2'b11; set_win(1000, 650, 100, 0, 1, 1);
    step(80);
    mode = 2'b00; set_win(495, 0, 0, 20, 0, 2);
    step(80);
    finish_run();
  end
endmodule